// File: doc/BRIEF.md
# Snapshot Sample Buffer with Serial Block Dump

This block records a run of converter samples into an on-chip memory and, once the memory is full, ships the whole recording to a host over an 8N1 UART transmitter. Each sample arrives as a parallel word with a valid strobe. It passes through a holding register and is then written at the next free address. The block alternates between two phases. In the capture phase the serial line stays idle. In the dump phase capture is paused and the memory is read out in address order. Each word is sent as a run of bytes, least significant byte first, with nothing inserted between words.

When the final stop bit completes, the block gives a one-cycle done pulse and rewinds its pointers. It then either starts the next snapshot or, if the enable input is low, parks in an idle phase until enable returns. The host therefore receives gap-free snapshots without paying for one serial transaction per sample. Two flags show the capture and dump phases, for use by a control register interface. Everything runs on a single clock.

Top module: `snapshot_uart_buffer`

## Requirements
- R1: A synchronous active-high reset drives the serial line high, sets the capture flag, and clears the dump flag and the done pulse.
- R2: A sample is accepted only on a cycle where its valid strobe is high while the capture flag is set. Accepted samples take consecutive addresses starting at 0, whether they arrive back to back or spaced apart. Data presented without the strobe is never stored.
- R3: No serial activity takes place and the dump flag stays low until DEPTH samples have been accepted. The dump flag rises within four cycles of the cycle that presents the last of those samples.
- R4: The dump sends the entries from address 0 up to DEPTH-1. Each WIDTH-bit entry is sent as WIDTH/8 bytes, least significant byte first, and no extra bytes are sent.
- R5: Each byte is framed as one low start bit, eight data bits LSB first and one high stop bit. Every bit lasts CLKS_PER_BIT clock cycles.
- R6: Samples presented while the dump flag is set are discarded. They appear in no later dump.
- R7: When the last stop bit of a dump completes, the done pulse is high for exactly one cycle while the dump flag is still set. It comes after every byte of the block has been framed. On the next cycle the block is out of the dump phase, and if enable is high the next snapshot fills from address 0.
- R8: If enable is low when a dump ends, the block stays idle with both flags low and the line high, and ignores samples. Raising enable starts a fresh capture at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows a new capture to start after a dump |
| sampleData | input | WIDTH | Converter sample word |
| sampleValid | input | 1 | Qualifies sampleData for one cycle |
| uartTx | output | 1 | Serial output, idle high |
| capturing | output | 1 | High during the capture phase |
| dumping | output | 1 | High during the serial dump |
| blockDone | output | 1 | One-cycle pulse at the end of the final stop bit |

## Verification
The assertions watch the phase rules on every cycle:
- the two flags are never high together;
- the line stays idle throughout capture;
- the done pulse lasts one cycle, falls inside a dump and is never followed by another dump cycle;
- the reset state is correct.

Three things only the bench scenarios can show:
- that the decoded byte stream matches the accepted samples in order and framing;
- that strobe-less data and samples offered during a dump or while idle are dropped;
- that the pointers rewind, both for an immediate restart and for a restart after an enable-held idle period.

// File: rtl/snapshot_uart_pkg.sv
package snapshot_uart_pkg;

  typedef enum logic [2:0] {
    PH_CAPTURE,
    PH_LOAD,
    PH_SEND,
    PH_WAIT,
    PH_IDLE
  } snapPhase_t;

  // control -> datapath
  typedef struct packed {
    logic captureEn;
    logic loadWord;
    logic startByte;
    logic nextByte;
    logic clrPtrs;
  } snapStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic memFull;
    logic txDone;
    logic lastByte;
    logic lastWord;
  } snapStatus_t;

endpackage

// File: rtl/snapshot_datapath.sv
module snapshot_datapath
  import snapshot_uart_pkg::*;
#(
  parameter int DEPTH        = 1024,
  parameter int WIDTH        = 32,
  parameter int CLKS_PER_BIT = 564
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sampleData,
  input  logic             sampleValid,
  input  snapStrobes_t     strobes,
  output snapStatus_t      status,
  output logic             uartTx
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int BYTES = WIDTH / 8;
  localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int DW    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [WIDTH-1:0] holdData;
  logic             holdValid;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    wrCount;
  logic [CW-1:0]    rdCount;
  logic [WIDTH-1:0] txWord;
  logic [BW-1:0]    byteSel;
  logic [7:0]       byteOut;
  logic             doWrite;

  logic [8:0]       shiftReg;
  logic [DW-1:0]    baudCnt;
  logic [3:0]       bitIdx;
  logic             txBusy;
  logic             txDoneQ;

  assign doWrite = holdValid && strobes.captureEn && (wrCount != CW'(DEPTH));

  // holding register in front of the memory
  always_ff @(posedge clk) begin
    if (rst) holdValid <= 1'b0;
    else     holdValid <= sampleValid && strobes.captureEn;
  end

  always_ff @(posedge clk) begin
    if (sampleValid) holdData <= sampleData;
  end

  // capture memory: write during capture, registered read during dump
  always_ff @(posedge clk) begin
    if (doWrite)          mem[wrCount[AW-1:0]] <= holdData;
    if (strobes.loadWord) txWord <= mem[rdCount[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clrPtrs) begin
      wrCount <= '0;
      rdCount <= '0;
    end else begin
      if (doWrite)          wrCount <= wrCount + 1'b1;
      if (strobes.loadWord) rdCount <= rdCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.loadWord) byteSel <= '0;
    else if (strobes.nextByte)   byteSel <= byteSel + 1'b1;
  end

  always_comb begin
    byteOut = txWord[8*int'(byteSel) +: 8];
  end

  // 8N1 serializer
  always_ff @(posedge clk) begin
    if (rst) begin
      uartTx   <= 1'b1;
      txBusy   <= 1'b0;
      txDoneQ  <= 1'b0;
      shiftReg <= '1;
      baudCnt  <= '0;
      bitIdx   <= '0;
    end else begin
      txDoneQ <= 1'b0;
      if (strobes.startByte && !txBusy) begin
        uartTx   <= 1'b0;
        shiftReg <= {1'b1, byteOut};
        txBusy   <= 1'b1;
        baudCnt  <= '0;
        bitIdx   <= '0;
      end else if (txBusy) begin
        if (baudCnt == DW'(CLKS_PER_BIT - 1)) begin
          baudCnt <= '0;
          if (bitIdx == 4'd9) begin
            txBusy  <= 1'b0;
            txDoneQ <= 1'b1;
            uartTx  <= 1'b1;
          end else begin
            uartTx   <= shiftReg[0];
            shiftReg <= {1'b1, shiftReg[8:1]};
            bitIdx   <= bitIdx + 1'b1;
          end
        end else begin
          baudCnt <= baudCnt + 1'b1;
        end
      end
    end
  end

  assign status.memFull  = (wrCount == CW'(DEPTH));
  assign status.lastWord = (rdCount == CW'(DEPTH));
  assign status.lastByte = (byteSel == BW'(BYTES - 1));
  assign status.txDone   = txDoneQ;

endmodule

// File: rtl/snapshot_control.sv
module snapshot_control
  import snapshot_uart_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  snapStatus_t  status,
  output snapStrobes_t strobes,
  output logic         capturing,
  output logic         dumping,
  output logic         blockDone
);

  snapPhase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_CAPTURE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    blockDone = 1'b0;
    unique case (phase)
      PH_CAPTURE: begin
        strobes.captureEn = 1'b1;
        if (status.memFull) phaseNext = PH_LOAD;
      end
      PH_LOAD: begin
        strobes.loadWord = 1'b1;
        phaseNext = PH_SEND;
      end
      PH_SEND: begin
        strobes.startByte = 1'b1;
        phaseNext = PH_WAIT;
      end
      PH_WAIT: begin
        if (status.txDone) begin
          if (!status.lastByte) begin
            strobes.nextByte = 1'b1;
            phaseNext = PH_SEND;
          end else if (!status.lastWord) begin
            phaseNext = PH_LOAD;
          end else begin
            blockDone       = 1'b1;
            strobes.clrPtrs = 1'b1;
            phaseNext = enable ? PH_CAPTURE : PH_IDLE;
          end
        end
      end
      PH_IDLE: begin
        if (enable) begin
          strobes.clrPtrs = 1'b1;
          phaseNext = PH_CAPTURE;
        end
      end
      default: phaseNext = PH_CAPTURE;
    endcase
  end

  assign capturing = (phase == PH_CAPTURE);
  assign dumping   = (phase == PH_LOAD) || (phase == PH_SEND) || (phase == PH_WAIT);

endmodule

// File: rtl/snapshot_uart_buffer.sv
module snapshot_uart_buffer
  import snapshot_uart_pkg::*;
#(
  parameter int DEPTH        = 1024,
  parameter int WIDTH        = 32,
  parameter int CLKS_PER_BIT = 564
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] sampleData,
  input  logic             sampleValid,
  output logic             uartTx,
  output logic             capturing,
  output logic             dumping,
  output logic             blockDone
);

  snapStrobes_t strobes;
  snapStatus_t  status;

  snapshot_datapath #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_dp (
    .clk(clk), .rst(rst),
    .sampleData(sampleData), .sampleValid(sampleValid),
    .strobes(strobes), .status(status), .uartTx(uartTx)
  );

  snapshot_control u_ctl (
    .clk(clk), .rst(rst), .enable(enable),
    .status(status), .strobes(strobes),
    .capturing(capturing), .dumping(dumping), .blockDone(blockDone)
  );

endmodule

// File: rtl/snapshot_uart_buffer_chk.sv
module snapshot_uart_buffer_chk (
  input logic clk,
  input logic rst,
  input logic uartTx,
  input logic capturing,
  input logic dumping,
  input logic blockDone
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (uartTx && capturing && !dumping && !blockDone));

  a_r3_line_idle_in_capture: assert property (@(posedge clk) disable iff (rst)
    capturing |-> uartTx);

  a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(capturing && dumping));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    blockDone |=> !blockDone);

  a_r7_done_inside_dump: assert property (@(posedge clk) disable iff (rst)
    blockDone |-> (dumping && uartTx));

  a_r7_dump_ends_after_done: assert property (@(posedge clk) disable iff (rst)
    blockDone |=> !dumping);

  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    (!capturing && !dumping) |-> uartTx);

endmodule

bind snapshot_uart_buffer snapshot_uart_buffer_chk u_chk (
  .clk(clk), .rst(rst), .uartTx(uartTx),
  .capturing(capturing), .dumping(dumping), .blockDone(blockDone)
);

// File: tb/sim_snapshot_uart_buffer.sv
module sim_snapshot_uart_buffer;

  localparam int DEPTH = 8;
  localparam int WIDTH = 32;
  localparam int CPB   = 8;
  localparam int BYTES = WIDTH / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic [WIDTH-1:0] sampleData = '0;
  logic sampleValid = 1'b0;
  logic uartTx, capturing, dumping, blockDone;

  int testsRun = 0;
  int testsFailed = 0;
  int rxBytes = 0;
  int doneCnt = 0;
  bit finished = 1'b0;
  logic [7:0] expQ [$];

  always #2 clk = ~clk;

  snapshot_uart_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst(rst), .enable(enable),
    .sampleData(sampleData), .sampleValid(sampleValid),
    .uartTx(uartTx), .capturing(capturing), .dumping(dumping), .blockDone(blockDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: offers one sample; push=1 records its bytes as expected output
  task automatic sendSample(input logic [WIDTH-1:0] d, input bit push, input int gap);
    sampleValid = 1'b1;
    sampleData  = d;
    if (push) for (int b = 0; b < BYTES; b++) expQ.push_back(d[8*b +: 8]);
    @(negedge clk);
    sampleValid = 1'b0;
    sampleData  = ~d;   // strobe-less data must never be stored (R2)
    repeat (gap) @(negedge clk);
  endtask

  // offer junk every dump cycle until the done pulse (R6)
  task automatic junkUntilDone(input logic [WIDTH-1:0] seed);
    bit fin = 1'b0;
    int n = 0;
    while (!fin) begin
      @(negedge clk);
      fin = blockDone;
      sampleValid = dumping;
      sampleData  = seed + WIDTH'(n);
      n++;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic fillBlock(input logic [WIDTH-1:0] base);
    for (int i = 0; i < DEPTH - 1; i++)
      sendSample(base + WIDTH'(i) * 32'h0102_0304, 1'b1, i % 3);
    repeat (5) @(negedge clk);
    check(!dumping && uartTx && capturing, "R3 idle before full", {dumping, uartTx}, 32'h1);
    sendSample(base ^ 32'hFFFF_0000, 1'b1, 0);
    repeat (3) @(negedge clk);
    check(dumping, "R3 dump starts when full", dumping, 1);
  endtask

  // monitor: decode the UART line and compare against the scoreboard (R4, R5)
  initial begin
    logic [7:0] rx;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (!rst && uartTx == 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        check(uartTx == 1'b0, "R5 start bit", uartTx, 0);
        for (int k = 0; k < 8; k++) begin
          repeat (CPB) @(negedge clk);
          rx[k] = uartTx;
        end
        repeat (CPB) @(negedge clk);
        check(uartTx == 1'b1, "R5 stop bit", uartTx, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected extra byte", rx, 0);
        end else begin
          exp = expQ.pop_front();
          check(rx == exp, "R4 byte order", rx, exp);
        end
        rxBytes++;
      end
    end
  end

  // done-pulse monitor (R7)
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (blockDone) begin
        doneCnt++;
        check(!prev, "R7 done pulse width", prev, 0);
        check(rxBytes == doneCnt * DEPTH * BYTES, "R7 done after last byte",
              rxBytes, doneCnt * DEPTH * BYTES);
      end
      prev = blockDone;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(uartTx == 1'b1, "R1 line idle", uartTx, 1);
    check(capturing == 1'b1, "R1 capture flag", capturing, 1);
    check(dumping == 1'b0, "R1 dump flag", dumping, 0);
    check(blockDone == 1'b0, "R1 done pulse", blockDone, 0);

    // block 1: mixed back-to-back and spaced samples (R2)
    fillBlock(32'hA0B0_C0D0);
    junkUntilDone(32'hDEAD_0000);
    check(capturing && !dumping, "R7 capture resumes", {capturing, dumping}, 32'h2);

    // block 2: pointer rewound; enable dropped during dump (R8)
    fillBlock(32'h1357_9BDF);
    enable = 1'b0;
    junkUntilDone(32'hBAD0_0000);
    check(!capturing && !dumping, "R8 idle after dump", {capturing, dumping}, 0);
    for (int i = 0; i < DEPTH; i++) sendSample(32'hEEEE_0000 + WIDTH'(i), 1'b0, 1);
    repeat (20) @(negedge clk);
    check(uartTx && !dumping && !capturing, "R8 ignores samples when idle",
          {uartTx, dumping, capturing}, 32'h4);

    enable = 1'b1;
    repeat (2) @(negedge clk);
    check(capturing, "R8 capture restarts", capturing, 1);
    fillBlock(32'h0F1E_2D3C);
    junkUntilDone(32'hF00D_0000);

    repeat (4 * CPB) @(negedge clk);
    check(expQ.size() == 0, "R4 all expected bytes sent", expQ.size(), 0);
    check(rxBytes == 3 * DEPTH * BYTES, "R6 no discarded sample sent", rxBytes, 3 * DEPTH * BYTES);
    check(doneCnt == 3, "R7 one done per block", doneCnt, 3);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule